// File: doc/BRIEF.md
# ADC sample capture FIFO bridge

The bridge links an analog-to-digital converter, an external sample FIFO and a system-side reader. While the capture input is high, it tells the external FIFO to store every converter sample. Both external FIFO clocks run at the sample clock. In the sample-clock domain, the bridge then drains the external FIFO one word per cycle into a small internal FIFO. Draining continues only while the external FIFO reports that it is not almost empty and the internal FIFO has room. Each drained word is packed into a 16-bit sample: the overrange flag, one zero bit, and the 14 converter bits. In test mode the sample is replaced by a running transfer count instead.

The internal FIFO crosses into the system clock domain through Gray-coded pointers, each synchronised by two flip-flops. The system reads one sample at a time with a request that is qualified by its clock enable. The returned sample arrives with a valid flag one enabled cycle later. A level flag tells the reader when only a few samples remain.

Top module: `adc_capture_bridge`

## Requirements
- R1: `ext_wen_n` is low exactly while `capture` is high, with no dependence on any other input.
- R2: With `test_en` low, the stored sample is bit 15 = `adc_or`, bit 14 = 0 and bits 13:0 = `ext_din`. It is taken at the `smp_clk` rising edge where `ext_ren_n` is low, so the external FIFO presents its head word before that edge.
- R3: With `test_en` high, the stored sample is the number of transfers completed since reset, not counting the present one, taken modulo 2^16.
- R4: `ext_ren_n` is low only while `ext_ae_n` is high, the internal FIFO is not full and `rst` is low. Each `smp_clk` edge with `ext_ren_n` low moves exactly one word.
- R5: The internal FIFO holds 2^ADDR_W words (16 by default). It never overflows, and the reader receives the words in the order they were written.
- R6: At a `sys_clk` edge with `sys_ce` high, `rd_valid` becomes `rd_req` AND (FIFO not empty). When that result is 1, `rd_data` takes the oldest word and the word is removed.
- R7: At a `sys_clk` edge with `sys_ce` low, `rd_valid` and `rd_data` hold, and no word is removed.
- R8: `ififo_low` is high when the read-side view of the FIFO holds AE_LEVEL (default 2) words or fewer, and low otherwise.
- R9: `ext_rst_n` is low while `rst` is high. `ext_rclk` and `ext_wclk` both equal `smp_clk`.
- R10: During and after reset, before any transfer, `rd_valid` is 0 and `ififo_low` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Asynchronous active-high reset for both domains |
| sys_clk | input | 1 | System read clock |
| sys_ce | input | 1 | System clock enable |
| rd_req | input | 1 | Read request for one sample |
| rd_data | output | 16 | Sample delivered to the system |
| rd_valid | output | 1 | rd_data holds a fresh sample |
| ififo_low | output | 1 | Internal FIFO at or below the low level |
| smp_clk | input | 1 | Sample-rate clock |
| capture | input | 1 | Store converter samples in the external FIFO |
| test_en | input | 1 | Substitute the transfer count for sample data |
| adc_or | input | 1 | Overrange flag travelling with the head word |
| ext_din | input | 14 | Head word of the external FIFO |
| ext_wen_n | output | 1 | External FIFO write enable, active low |
| ext_ren_n | output | 1 | External FIFO read enable, active low |
| ext_rst_n | output | 1 | External FIFO reset, active low |
| ext_ae_n | input | 1 | External FIFO almost empty, active low |
| ext_ir_n | input | 1 | External FIFO input ready, active low (not used by the logic) |
| ext_rclk | output | 1 | External FIFO read clock |
| ext_wclk | output | 1 | External FIFO write clock |

## Verification
The assertions check several rules on every clock:
- a read never starts while the external FIFO reports almost empty, and never during reset;
- the occupancy seen from the write side never exceeds the depth;
- an empty FIFO always shows the low flag;
- a disabled system cycle freezes the outputs;
- a cycle without a request clears the valid flag.

Only the bench scenarios can show the rest. These are the exact bit packing and the count substitution, the preserved write order across the clock crossing, the stop at exactly sixteen words, and the level flag switching at the right occupancy.

// File: rtl/adc_capture_bridge.sv
module adc_capture_bridge #(
  parameter int ADC_W    = 14,
  parameter int SMP_W    = 16,
  parameter int ADDR_W   = 4,
  parameter int AE_LEVEL = 2
) (
  input  logic             rst,
  input  logic             sys_clk,
  input  logic             sys_ce,
  input  logic             rd_req,
  output logic [SMP_W-1:0] rd_data,
  output logic             rd_valid,
  output logic             ififo_low,
  input  logic             smp_clk,
  input  logic             capture,
  input  logic             test_en,
  input  logic             adc_or,
  input  logic [ADC_W-1:0] ext_din,
  output logic             ext_wen_n,
  output logic             ext_ren_n,
  output logic             ext_rst_n,
  input  logic             ext_ae_n,
  input  logic             ext_ir_n,
  output logic             ext_rclk,
  output logic             ext_wclk
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PW    = ADDR_W + 1;
  localparam int PAD_W = SMP_W - ADC_W - 1;
  localparam logic [PW-1:0] LOW_MARK = PW'(AE_LEVEL);

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [SMP_W-1:0] mem [DEPTH];

  logic [PW-1:0]    wbin, wgray, rgray_s1, rgray_s2;
  logic [SMP_W-1:0] tcount, packed_w;
  logic             wfull, ren;

  logic [PW-1:0]    rbin, rgray, wgray_s1, wgray_s2, wbin_r, level;
  logic             rempty, pop;

  logic             unused_ir;

  assign ext_wen_n = ~capture;
  assign ext_rst_n = ~rst;
  assign ext_rclk  = smp_clk;
  assign ext_wclk  = smp_clk;
  assign unused_ir = ext_ir_n;

  assign wfull    = (wgray == {~rgray_s2[PW-1:PW-2], rgray_s2[PW-3:0]});
  assign ren      = ext_ae_n & ~wfull & ~rst;
  assign ext_ren_n = ~ren;
  assign packed_w = test_en ? tcount : {adc_or, {PAD_W{1'b0}}, ext_din};

  always_ff @(posedge smp_clk or posedge rst) begin
    if (rst) begin
      wbin     <= '0;
      wgray    <= '0;
      tcount   <= '0;
      rgray_s1 <= '0;
      rgray_s2 <= '0;
    end else begin
      rgray_s1 <= rgray;
      rgray_s2 <= rgray_s1;
      if (ren) begin
        wbin   <= wbin + 1'b1;
        wgray  <= to_gray(wbin + 1'b1);
        tcount <= tcount + 1'b1;
      end
    end
  end

  always_ff @(posedge smp_clk) begin
    if (ren) mem[wbin[ADDR_W-1:0]] <= packed_w;
  end

  assign rempty    = (rgray == wgray_s2);
  assign wbin_r    = from_gray(wgray_s2);
  assign level     = wbin_r - rbin;
  assign ififo_low = (level <= LOW_MARK);
  assign pop       = sys_ce & rd_req & ~rempty;

  always_ff @(posedge sys_clk or posedge rst) begin
    if (rst) begin
      rbin     <= '0;
      rgray    <= '0;
      wgray_s1 <= '0;
      wgray_s2 <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      wgray_s1 <= wgray;
      wgray_s2 <= wgray_s1;
      if (sys_ce) rd_valid <= rd_req & ~rempty;
      if (pop) begin
        rd_data <= mem[rbin[ADDR_W-1:0]];
        rbin    <= rbin + 1'b1;
        rgray   <= to_gray(rbin + 1'b1);
      end
    end
  end
endmodule

module adc_capture_bridge_chk #(
  parameter int SMP_W  = 16,
  parameter int ADDR_W = 4
) (
  input logic             rst,
  input logic             sys_clk,
  input logic             smp_clk,
  input logic             sys_ce,
  input logic             rd_req,
  input logic             rd_valid,
  input logic [SMP_W-1:0] rd_data,
  input logic             ififo_low,
  input logic             ext_ae_n,
  input logic             ext_ren_n,
  input logic             ext_rst_n,
  input logic             rempty,
  input logic [ADDR_W:0]  wbin,
  input logic [ADDR_W:0]  rgray_s2
);
  localparam int PW = ADDR_W + 1;
  localparam logic [PW-1:0] DEPTH_V = PW'(1 << ADDR_W);

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PW-1:0] occ_w;
  assign occ_w = wbin - g2b(rgray_s2);

  AST_NO_DRAIN_WHEN_AE: assert property (@(posedge smp_clk) disable iff (rst) !ext_ae_n |-> ext_ren_n); // R4
  AST_NO_DRAIN_IN_RESET: assert property (@(posedge smp_clk) rst |-> (ext_ren_n && !ext_rst_n)); // R9
  AST_NO_OVERFLOW: assert property (@(posedge smp_clk) disable iff (rst) occ_w <= DEPTH_V); // R5
  AST_LOW_WHEN_EMPTY: assert property (@(posedge sys_clk) disable iff (rst) rempty |-> ififo_low); // R8
  AST_HOLD_WITHOUT_CE: assert property (@(posedge sys_clk) disable iff (rst) !sys_ce |=> ($stable(rd_valid) && $stable(rd_data))); // R7
  AST_NO_REQ_NO_VALID: assert property (@(posedge sys_clk) disable iff (rst) (sys_ce && !rd_req) |=> !rd_valid); // R6
endmodule

bind adc_capture_bridge adc_capture_bridge_chk #(.SMP_W(SMP_W), .ADDR_W(ADDR_W)) u_chk (
  .rst(rst), .sys_clk(sys_clk), .smp_clk(smp_clk), .sys_ce(sys_ce), .rd_req(rd_req),
  .rd_valid(rd_valid), .rd_data(rd_data), .ififo_low(ififo_low), .ext_ae_n(ext_ae_n),
  .ext_ren_n(ext_ren_n), .ext_rst_n(ext_rst_n), .rempty(rempty), .wbin(wbin),
  .rgray_s2(rgray_s2)
);

// File: tb/adc_capture_bridge_tb.sv
module adc_capture_bridge_tb;
  logic rst = 1'b1, sys_clk = 1'b0, smp_clk = 1'b0;
  logic sys_ce = 1'b1, rd_req = 1'b0, capture = 1'b0, test_en = 1'b0, adc_or = 1'b0;
  logic ext_ae_n = 1'b0, ext_ir_n = 1'b0;
  logic [13:0] ext_din = '0;
  logic [15:0] rd_data;
  logic rd_valid, ififo_low, ext_wen_n, ext_ren_n, ext_rst_n, ext_rclk, ext_wclk;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #4 sys_clk = ~sys_clk;
  always #5 smp_clk = ~smp_clk;

  adc_capture_bridge u_dut (
    .rst(rst), .sys_clk(sys_clk), .sys_ce(sys_ce), .rd_req(rd_req), .rd_data(rd_data),
    .rd_valid(rd_valid), .ififo_low(ififo_low), .smp_clk(smp_clk), .capture(capture),
    .test_en(test_en), .adc_or(adc_or), .ext_din(ext_din), .ext_wen_n(ext_wen_n),
    .ext_ren_n(ext_ren_n), .ext_rst_n(ext_rst_n), .ext_ae_n(ext_ae_n), .ext_ir_n(ext_ir_n),
    .ext_rclk(ext_rclk), .ext_wclk(ext_wclk)
  );

  // {test_en, adc_or, ext_din[13:0], expected[15:0]}
  localparam logic [31:0] VEC [8] = '{
    {1'b0, 1'b0, 14'h0000, 16'h0000},
    {1'b0, 1'b1, 14'h3FFF, 16'hBFFF},
    {1'b0, 1'b0, 14'h1234, 16'h1234},
    {1'b1, 1'b1, 14'h2AAA, 16'h0003},
    {1'b0, 1'b1, 14'h0001, 16'h8001},
    {1'b1, 1'b0, 14'h3FFF, 16'h0005},
    {1'b0, 1'b0, 14'h2AAA, 16'h2AAA},
    {1'b0, 1'b1, 14'h1555, 16'h9555}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic t, input logic o, input logic [13:0] d);
    @(negedge smp_clk);
    test_en = t; adc_or = o; ext_din = d; ext_ae_n = 1'b1;
    #1 chk("R4 drain enabled", 32'(ext_ren_n), 32'd0);
    @(negedge smp_clk);
    ext_ae_n = 1'b0;
    #1 chk("R4 drain stopped by almost-empty", 32'(ext_ren_n), 32'd1);
  endtask

  task automatic read_one(input string req, input logic exp_v, input logic [15:0] exp_d);
    @(negedge sys_clk);
    sys_ce = 1'b1; rd_req = 1'b1;
    @(negedge sys_clk);
    rd_req = 1'b0;
    chk(req, 32'(rd_valid), 32'(exp_v));
    if (exp_v) chk(req, 32'(rd_data), 32'(exp_d));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finish_run();
  end

  initial begin
    ext_ae_n = 1'b1;
    #23;
    chk("R9 external reset during rst", 32'(ext_rst_n), 32'd0);
    chk("R4 no drain during rst", 32'(ext_ren_n), 32'd1);
    chk("R10 rd_valid in reset", 32'(rd_valid), 32'd0);
    chk("R10 ififo_low in reset", 32'(ififo_low), 32'd1);
    ext_ae_n = 1'b0;
    @(negedge smp_clk); rst = 1'b0;
    #1 chk("R9 external reset released", 32'(ext_rst_n), 32'd1);
    chk("R9 rclk equals smp_clk", 32'(ext_rclk), 32'(smp_clk));
    chk("R9 wclk equals smp_clk", 32'(ext_wclk), 32'(smp_clk));
    @(posedge smp_clk); #1;
    chk("R9 rclk equals smp_clk high", 32'(ext_rclk), 32'(smp_clk));
    chk("R9 wclk equals smp_clk high", 32'(ext_wclk), 32'(smp_clk));

    capture = 1'b1; #1 chk("R1 write enable active", 32'(ext_wen_n), 32'd0);
    ext_ae_n = 1'b1; #1 chk("R1 unaffected by other inputs", 32'(ext_wen_n), 32'd0);
    ext_ae_n = 1'b0;
    capture = 1'b0; #1 chk("R1 write enable idle", 32'(ext_wen_n), 32'd1);

    read_one("R6 read from empty", 1'b0, 16'h0);
    chk("R10 ififo_low after reset", 32'(ififo_low), 32'd1);

    for (int i = 0; i < 8; i++) push(VEC[i][31], VEC[i][30], VEC[i][29:16]);
    repeat (8) @(negedge sys_clk);
    chk("R8 ififo_low with 8 words", 32'(ififo_low), 32'd0);

    for (int i = 0; i < 8; i++) begin
      read_one(VEC[i][31] ? "R3 count substitution" : "R2 packing", 1'b1, VEC[i][15:0]);
      if (i == 0) begin
        sys_ce = 1'b1; rd_req = 1'b0;
        @(posedge sys_clk); #1 sys_ce = 1'b0; rd_req = 1'b1;
        repeat (3) @(negedge sys_clk);
        chk("R7 valid held with ce low", 32'(rd_valid), 32'd0);
        sys_ce = 1'b0; rd_req = 1'b0;
      end
    end
    read_one("R6 read after drain", 1'b0, 16'h0);

    read_one("R6 empty again", 1'b0, 16'h0);
    push(1'b0, 1'b1, 14'h0ABC);
    repeat (8) @(negedge sys_clk);
    read_one("R2 packing single", 1'b1, 16'h8ABC);
    sys_ce = 1'b0; rd_req = 1'b1;
    repeat (3) @(negedge sys_clk);
    chk("R7 valid held", 32'(rd_valid), 32'd1);
    chk("R7 data held", 32'(rd_data), 32'h8ABC);
    rd_req = 1'b0; sys_ce = 1'b1;

    @(negedge smp_clk);
    test_en = 1'b1; ext_ae_n = 1'b1;
    repeat (24) @(negedge smp_clk);
    chk("R4 drain stops when full", 32'(ext_ren_n), 32'd1);
    ext_ae_n = 1'b0;
    repeat (8) @(negedge sys_clk);
    for (int i = 0; i < 16; i++) begin
      if (i == 13) chk("R8 ififo_low with 3 words", 32'(ififo_low), 32'd0);
      if (i == 14) chk("R8 ififo_low with 2 words", 32'(ififo_low), 32'd1);
      read_one("R5 order and depth", 1'b1, 16'(9 + i));
    end
    read_one("R5 exactly sixteen stored", 1'b0, 16'h0);

    finish_run();
  end
endmodule